// File: doc/BRIEF.md
# DMA Control Port Group

This block holds the control state of a four-channel DMA engine: the command byte, one mode byte per channel, a four-bit channel mask and an eight-bit status byte. The status byte carries one request bit and one terminal-count bit for each channel. Software reaches the block through eight control port indices, 0x8 to 0xF. Each index has its own side effect on a write: a command load, a software request, a single-channel mask change, a mode load, a byte-pointer clear, a master reset, a mask clear-all or a mask load-all. Indices 0x0 to 0x7 belong to the channel address and count registers. This block ignores writes to them and reads them as zero.

The transfer side drives per-channel hold and release inputs, which set and clear the request bits, and a per-channel terminal-count strobe. The block passes the mask, the request bits, the command, the modes and a one-cycle byte-pointer clear pulse to the channel registers and the arbiter. Every output is registered. Read data appears one cycle after the read strobe.

Top module: `dma_ctl_regs`

## Requirements
- R1: While `rst` is high and on the first cycle after it, the outputs are: `mask_o` all ones, `req_o` zero, `cmd_o` zero, every mode byte zero, `rd_data` zero, `cmd_err` zero and `ff_clr` zero. The status byte reads as zero.
- R2: A write to index 0x8 of 0x00 or 0x04 loads `cmd_o` on the next cycle. Any value with a bit other than bit 2 set is rejected: `cmd_o` keeps its value and `cmd_err` is high for exactly the next cycle.
- R3: A write to index 0x9 selects channel `wr_data[1:0]`. With `wr_data[2]`=1 it sets that channel's request bit. With `wr_data[2]`=0 it clears that request bit and that channel's terminal-count bit.
- R4: A write to index 0xA sets mask bit `wr_data[1:0]` when `wr_data[2]`=1 and clears it when `wr_data[2]`=0. The other mask bits are unchanged.
- R5: A write to index 0xB stores the whole data byte as the mode of channel `wr_data[1:0]`. Channel c's mode is on `mode_o[8c+7:8c]`, and the other channels' modes are unchanged.
- R6: A write to index 0xC makes `ff_clr` high for exactly the next cycle.
- R7: A write to index 0xD is a master reset. On the next cycle `ff_clr` pulses, the status byte and `cmd_o` are zero and `mask_o` is all ones. The modes are kept. The master reset overrides same-cycle hold and terminal-count inputs.
- R8: A write to index 0xE clears all mask bits. A write to index 0xF loads the mask from `wr_data[3:0]`.
- R9: A read registers `rd_data` on the next cycle. Index 0x8 returns the status byte, with the request bits in [7:4] and the terminal-count bits in [3:0], channel n at bit n of each nibble. Index 0xF returns the mask in [3:0] with the upper bits zero. Every other index returns 0x00.
- R10: A read of index 0x8 clears all terminal-count bits once the returned value has been captured.
- R11: `hold_req[n]` sets request bit n and `release_req[n]` clears it, and hold wins when both are high. A same-cycle software write to index 0x9 for that channel overrides both.
- R12: `tc_hit[n]` sets terminal-count bit n. It wins over a same-cycle status read or software clear, but not over a master reset.
- R13: A write to an index in 0x0 to 0x7 changes no output and no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control write strobe |
| rd_en | input | 1 | Control read strobe |
| port_idx | input | 4 | Port index of the access |
| wr_data | input | 8 | Write data |
| hold_req | input | 4 | Per-channel request set from the transfer side |
| release_req | input | 4 | Per-channel request clear from the transfer side |
| tc_hit | input | 4 | Per-channel terminal-count strobe |
| rd_data | output | 8 | Registered read data |
| cmd_o | output | 8 | Command byte |
| cmd_err | output | 1 | One-cycle pulse on a rejected command |
| mask_o | output | 4 | Channel mask, 1 = masked |
| req_o | output | 4 | Channel request bits |
| mode_o | output | 32 | Packed per-channel mode bytes |
| ff_clr | output | 1 | One-cycle byte-pointer clear pulse |

## Verification
Mask, request, command and mode state all appear on output ports, so a wrong update shows up one cycle after the write that caused it. The terminal-count bits can only be seen through a status read. A missed set or a clear-on-read that fires wrongly therefore shows up two cycles later, on the registered read data of the next status read. The bench reads status often so that this lag stays short. Same-cycle conflicts between hold, release, software requests, terminal count and master reset are driven on purpose, because a wrong precedence shows up only in those cycles.

// File: rtl/dma_ctl_pkg.sv
package dma_ctl_pkg;

  localparam logic [3:0] IDX_CMD   = 4'h8;
  localparam logic [3:0] IDX_SWREQ = 4'h9;
  localparam logic [3:0] IDX_SMASK = 4'hA;
  localparam logic [3:0] IDX_MODE  = 4'hB;
  localparam logic [3:0] IDX_FFCLR = 4'hC;
  localparam logic [3:0] IDX_MRST  = 4'hD;
  localparam logic [3:0] IDX_MCLR  = 4'hE;
  localparam logic [3:0] IDX_MALL  = 4'hF;

  // Only the controller-disable bit may be set in an accepted command
  localparam logic [7:0] CMD_ALLOWED = 8'h04;

  typedef struct packed {
    logic cmd;
    logic swreq;
    logic smask;
    logic mode;
    logic ffclr;
    logic mrst;
    logic mclr;
    logic mall;
    logic rd_stat;
    logic rd_mask;
  } ctl_strobe_t;

endpackage

// File: rtl/dma_ctl_decode.sv
module dma_ctl_decode
  import dma_ctl_pkg::*;
(
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [3:0]  port_idx,
  output ctl_strobe_t stb
);

  always_comb begin
    stb = '0;
    if (wr_en) begin
      case (port_idx)
        IDX_CMD:   stb.cmd   = 1'b1;
        IDX_SWREQ: stb.swreq = 1'b1;
        IDX_SMASK: stb.smask = 1'b1;
        IDX_MODE:  stb.mode  = 1'b1;
        IDX_FFCLR: stb.ffclr = 1'b1;
        IDX_MRST:  stb.mrst  = 1'b1;
        IDX_MCLR:  stb.mclr  = 1'b1;
        IDX_MALL:  stb.mall  = 1'b1;
        default:   ;
      endcase
    end
    if (rd_en) begin
      stb.rd_stat = (port_idx == IDX_CMD);
      stb.rd_mask = (port_idx == IDX_MALL);
    end
  end

endmodule

// File: rtl/dma_ctl_mask.sv
module dma_ctl_mask #(
  parameter int NCH = 4,
  localparam int CW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           mrst,
  input  logic           mclr,
  input  logic           mall,
  input  logic           smask,
  input  logic [CW-1:0]  sel,
  input  logic           set_bit,
  input  logic [NCH-1:0] all_val,
  output logic [NCH-1:0] mask_q
);

  always_ff @(posedge clk) begin
    if (rst || mrst) begin
      mask_q <= '1;
    end else if (mclr) begin
      mask_q <= '0;
    end else if (mall) begin
      mask_q <= all_val;
    end else if (smask) begin
      mask_q[sel] <= set_bit;
    end
  end

endmodule

// File: rtl/dma_ctl_status.sv
module dma_ctl_status #(
  parameter int NCH = 4,
  localparam int CW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           mrst,
  input  logic           swreq,
  input  logic [CW-1:0]  sel,
  input  logic           set_bit,
  input  logic           rd_stat,
  input  logic [NCH-1:0] hold_req,
  input  logic [NCH-1:0] release_req,
  input  logic [NCH-1:0] tc_hit,
  output logic [NCH-1:0] req_q,
  output logic [NCH-1:0] tc_q
);

  logic [NCH-1:0] req_n;
  logic [NCH-1:0] tc_n;

  // Precedence, lowest first: external inputs, software request, tc set
  always_comb begin
    req_n = (req_q & ~release_req) | hold_req;
    tc_n  = rd_stat ? '0 : tc_q;
    if (swreq) begin
      req_n[sel] = set_bit;
      if (!set_bit) tc_n[sel] = 1'b0;
    end
    tc_n = tc_n | tc_hit;
  end

  always_ff @(posedge clk) begin
    if (rst || mrst) begin
      req_q <= '0;
      tc_q  <= '0;
    end else begin
      req_q <= req_n;
      tc_q  <= tc_n;
    end
  end

endmodule

// File: rtl/dma_ctl_modes.sv
module dma_ctl_modes #(
  parameter int NCH = 4,
  parameter int DW  = 8,
  localparam int CW = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [CW-1:0]     sel,
  input  logic [DW-1:0]     wdata,
  output logic [NCH*DW-1:0] mode_flat
);

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    logic [DW-1:0] mode_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        mode_q <= '0;
      end else if (we && (sel == CW'(c))) begin
        mode_q <= wdata;
      end
    end
    assign mode_flat[c*DW +: DW] = mode_q;
  end

endmodule

// File: rtl/dma_ctl_regs.sv
module dma_ctl_regs
  import dma_ctl_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = 8,
  localparam int CW = $clog2(NCH),
  localparam int SW = 2 * NCH
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [3:0]        port_idx,
  input  logic [DW-1:0]     wr_data,
  input  logic [NCH-1:0]    hold_req,
  input  logic [NCH-1:0]    release_req,
  input  logic [NCH-1:0]    tc_hit,
  output logic [DW-1:0]     rd_data,
  output logic [DW-1:0]     cmd_o,
  output logic              cmd_err,
  output logic [NCH-1:0]    mask_o,
  output logic [NCH-1:0]    req_o,
  output logic [NCH*DW-1:0] mode_o,
  output logic              ff_clr
);

  ctl_strobe_t    stb;
  logic [NCH-1:0] tc_q;
  logic [CW-1:0]  sel;
  logic           set_bit;
  logic           cmd_ok;

  assign sel     = wr_data[CW-1:0];
  assign set_bit = wr_data[CW];
  assign cmd_ok  = ((wr_data & ~DW'(CMD_ALLOWED)) == '0);

  dma_ctl_decode u_dec (
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .port_idx (port_idx),
    .stb      (stb)
  );

  dma_ctl_mask #(.NCH(NCH)) u_mask (
    .clk     (clk),
    .rst     (rst),
    .mrst    (stb.mrst),
    .mclr    (stb.mclr),
    .mall    (stb.mall),
    .smask   (stb.smask),
    .sel     (sel),
    .set_bit (set_bit),
    .all_val (wr_data[NCH-1:0]),
    .mask_q  (mask_o)
  );

  dma_ctl_status #(.NCH(NCH)) u_stat (
    .clk         (clk),
    .rst         (rst),
    .mrst        (stb.mrst),
    .swreq       (stb.swreq),
    .sel         (sel),
    .set_bit     (set_bit),
    .rd_stat     (stb.rd_stat),
    .hold_req    (hold_req),
    .release_req (release_req),
    .tc_hit      (tc_hit),
    .req_q       (req_o),
    .tc_q        (tc_q)
  );

  dma_ctl_modes #(.NCH(NCH), .DW(DW)) u_modes (
    .clk       (clk),
    .rst       (rst),
    .we        (stb.mode),
    .sel       (sel),
    .wdata     (wr_data),
    .mode_flat (mode_o)
  );

  always_ff @(posedge clk) begin
    if (rst || stb.mrst) begin
      cmd_o <= '0;
    end else if (stb.cmd && cmd_ok) begin
      cmd_o <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_err <= 1'b0;
      ff_clr  <= 1'b0;
      rd_data <= '0;
    end else begin
      cmd_err <= stb.cmd && !cmd_ok;
      ff_clr  <= stb.ffclr || stb.mrst;
      if (stb.rd_stat)      rd_data <= DW'({req_o, tc_q});
      else if (stb.rd_mask) rd_data <= DW'(mask_o);
      else                  rd_data <= '0;
    end
  end

endmodule

// File: rtl/dma_ctl_regs_chk.sv
module dma_ctl_regs_chk #(
  parameter int NCH = 4,
  parameter int DW  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [3:0]        port_idx,
  input logic [DW-1:0]     wr_data,
  input logic [NCH-1:0]    hold_req,
  input logic [NCH-1:0]    release_req,
  input logic [DW-1:0]     rd_data,
  input logic [DW-1:0]     cmd_o,
  input logic              cmd_err,
  input logic [NCH-1:0]    mask_o,
  input logic [NCH-1:0]    req_o,
  input logic [NCH*DW-1:0] mode_o,
  input logic              ff_clr
);

  p_cmd_reject_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && port_idx == 4'h8 && (wr_data & ~DW'(8'h04)) != '0)
      |=> (cmd_err && $stable(cmd_o)));

  p_swreq_set_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && port_idx == 4'h9 && wr_data[2])
      |=> req_o[$past(wr_data[1:0])]);

  p_mask_single_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && port_idx == 4'hA)
      |=> (mask_o[$past(wr_data[1:0])] == $past(wr_data[2])));

  p_ffclr_cause_r6: assert property (@(posedge clk) disable iff (rst)
    ff_clr |-> $past(wr_en && (port_idx == 4'hC || port_idx == 4'hD)));

  p_master_reset_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && port_idx == 4'hD)
      |=> (mask_o == '1 && req_o == '0 && cmd_o == '0 && ff_clr && $stable(mode_o)));

  p_mask_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && port_idx == 4'hE) |=> (mask_o == '0));

  p_rd_other_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && port_idx != 4'h8 && port_idx != 4'hF) |=> (rd_data == '0));

  p_hold_sets_r11: assert property (@(posedge clk) disable iff (rst)
    (hold_req[0] && !(wr_en && (port_idx == 4'h9 || port_idx == 4'hD)))
      |=> req_o[0]);

  p_ignored_write_r13: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !port_idx[3] && hold_req == '0 && release_req == '0)
      |=> ($stable(mask_o) && $stable(cmd_o) && $stable(mode_o) && $stable(req_o) && !ff_clr && !cmd_err));

endmodule

bind dma_ctl_regs dma_ctl_regs_chk #(.NCH(NCH), .DW(DW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .wr_en       (wr_en),
  .rd_en       (rd_en),
  .port_idx    (port_idx),
  .wr_data     (wr_data),
  .hold_req    (hold_req),
  .release_req (release_req),
  .rd_data     (rd_data),
  .cmd_o       (cmd_o),
  .cmd_err     (cmd_err),
  .mask_o      (mask_o),
  .req_o       (req_o),
  .mode_o      (mode_o),
  .ff_clr      (ff_clr)
);

// File: tb/dma_ctl_regs_test.sv
`timescale 1ns/1ps
module dma_ctl_regs_test;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en, rd_en;
  logic [3:0]  port_idx;
  logic [7:0]  wr_data;
  logic [3:0]  hold_req, release_req, tc_hit;
  logic [7:0]  rd_data, cmd_o;
  logic        cmd_err, ff_clr;
  logic [3:0]  mask_o, req_o;
  logic [31:0] mode_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  logic [3:0] m_mask, m_req, m_tc;
  logic [7:0] m_cmd;
  logic [7:0] m_mode [4];
  logic [7:0] e_rd;
  logic       e_err, e_ff;

  always #10 clk = ~clk;

  dma_ctl_regs uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .port_idx(port_idx),
    .wr_data(wr_data), .hold_req(hold_req), .release_req(release_req),
    .tc_hit(tc_hit), .rd_data(rd_data), .cmd_o(cmd_o), .cmd_err(cmd_err),
    .mask_o(mask_o), .req_o(req_o), .mode_o(mode_o), .ff_clr(ff_clr)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input logic w, input logic r, input logic [3:0] idx);
    if (r) return (idx == 4'h8) ? "R10" : "R9";
    if (!w) return "R11";
    case (idx)
      4'h8: return "R2";
      4'h9: return "R3";
      4'hA: return "R4";
      4'hB: return "R5";
      4'hC: return "R6";
      4'hD: return "R7";
      4'hE, 4'hF: return "R8";
      default: return "R13";
    endcase
  endfunction

  function automatic logic [31:0] mode_flat();
    return {m_mode[3], m_mode[2], m_mode[1], m_mode[0]};
  endfunction

  task automatic compare(input string tag);
    chk(tag, "mask_o", 32'(mask_o), 32'(m_mask));
    chk(tag, "req_o", 32'(req_o), 32'(m_req));
    chk(tag, "cmd_o", 32'(cmd_o), 32'(m_cmd));
    chk(tag, "mode_o", mode_o, mode_flat());
    chk(tag, "rd_data", 32'(rd_data), 32'(e_rd));
    chk(tag, "cmd_err", 32'(cmd_err), 32'(e_err));
    chk(tag, "ff_clr", 32'(ff_clr), 32'(e_ff));
  endtask

  // Drives one cycle, advances the model, checks after the edge
  task automatic step(input logic w, input logic r, input logic [3:0] idx, input logic [7:0] d,
                      input logic [3:0] h, input logic [3:0] rl, input logic [3:0] tc, input string tag);
    logic [3:0] nreq, ntc;
    wr_en = w; rd_en = r; port_idx = idx; wr_data = d;
    hold_req = h; release_req = rl; tc_hit = tc;
    e_rd = 8'h00; e_err = 1'b0; e_ff = 1'b0;
    if (r && idx == 4'h8) e_rd = {m_req, m_tc};
    if (r && idx == 4'hF) e_rd = {4'h0, m_mask};
    nreq = (m_req & ~rl) | h;
    ntc  = (r && idx == 4'h8) ? 4'h0 : m_tc;
    if (w) begin
      case (idx)
        4'h8: if ((d & 8'hFB) == 8'h00) m_cmd = d; else e_err = 1'b1;
        4'h9: begin nreq[d[1:0]] = d[2]; if (!d[2]) ntc[d[1:0]] = 1'b0; end
        4'hA: m_mask[d[1:0]] = d[2];
        4'hB: m_mode[d[1:0]] = d;
        4'hC: e_ff = 1'b1;
        4'hE: m_mask = 4'h0;
        4'hF: m_mask = d[3:0];
        default: ;
      endcase
    end
    ntc = ntc | tc;
    if (w && idx == 4'hD) begin
      e_ff = 1'b1; m_cmd = 8'h00; m_mask = 4'hF; nreq = 4'h0; ntc = 4'h0;
    end
    m_req = nreq; m_tc = ntc;
    @(posedge clk); #1;
    compare(tag);
  endtask

  task automatic wr(input logic [3:0] idx, input logic [7:0] d, input string tag);
    step(1'b1, 1'b0, idx, d, 4'h0, 4'h0, 4'h0, tag);
  endtask

  task automatic rd(input logic [3:0] idx, input string tag);
    step(1'b0, 1'b1, idx, 8'h00, 4'h0, 4'h0, 4'h0, tag);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1977));
    rst = 1'b1; wr_en = 0; rd_en = 0; port_idx = 0; wr_data = 0;
    hold_req = 0; release_req = 0; tc_hit = 0;
    m_mask = 4'hF; m_req = 0; m_tc = 0; m_cmd = 0;
    for (int i = 0; i < 4; i++) m_mode[i] = 8'h00;
    e_rd = 0; e_err = 0; e_ff = 0;
    repeat (3) @(posedge clk);
    #1;
    compare("R1");
    rst = 1'b0;
    rd(4'h8, "R1");

    wr(4'h8, 8'h04, "R2");
    wr(4'h8, 8'h01, "R2");
    wr(4'h8, 8'h00, "R2");
    wr(4'h8, 8'h80, "R2");

    step(1'b0, 1'b0, 4'h0, 8'h00, 4'h0, 4'h0, 4'b0110, "R12");
    wr(4'h9, 8'h05, "R3");
    rd(4'h8, "R9");
    wr(4'h9, 8'h01, "R3");
    rd(4'h8, "R3");
    step(1'b0, 1'b1, 4'h8, 8'h00, 4'h0, 4'h0, 4'b0100, "R12");
    rd(4'h8, "R10");
    rd(4'h8, "R10");

    wr(4'hA, 8'h06, "R4");
    wr(4'hA, 8'h00, "R4");
    rd(4'hF, "R9");
    wr(4'hB, 8'hD7, "R5");
    wr(4'hB, 8'h2A, "R5");
    wr(4'hC, 8'h00, "R6");
    wr(4'hE, 8'h00, "R8");
    wr(4'hF, 8'h0A, "R8");

    step(1'b0, 1'b0, 4'h0, 8'h00, 4'b0011, 4'b0011, 4'h0, "R11");
    step(1'b1, 1'b0, 4'h9, 8'h00, 4'b0001, 4'h0, 4'h0, "R11");
    step(1'b1, 1'b0, 4'h9, 8'h07, 4'h0, 4'b1000, 4'h0, "R11");
    wr(4'h3, 8'hFF, "R13");
    rd(4'h2, "R9");
    step(1'b1, 1'b0, 4'hD, 8'h00, 4'hF, 4'h0, 4'hF, "R7");
    rd(4'h8, "R7");

    for (int i = 0; i < 3000; i++) begin
      logic w, r;
      logic [3:0] idx, h, rl, tc;
      logic [7:0] d;
      int sel;
      sel = int'($urandom_range(0, 9));
      w = (sel < 6); r = (sel >= 6) && (sel < 9);
      idx = 4'($urandom_range(0, 15));
      if (w && idx < 4'h8 && ($urandom_range(0, 3) != 0)) idx = idx | 4'h8;
      if (r && ($urandom_range(0, 1) == 1)) idx = 4'h8;
      d = 8'($urandom());
      if (w && idx == 4'h8 && ($urandom_range(0, 1) == 1)) d = d & 8'h04;
      if (w && idx == 4'hD && ($urandom_range(0, 3) != 0)) idx = 4'hB;
      h  = ($urandom_range(0, 3) == 0) ? 4'($urandom()) : 4'h0;
      rl = ($urandom_range(0, 3) == 0) ? 4'($urandom()) : 4'h0;
      tc = ($urandom_range(0, 3) == 0) ? 4'($urandom()) : 4'h0;
      step(w, r, idx, d, h, rl, tc, tag_of(w, r, idx));
    end
    rd(4'h8, "R10");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule